// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block receives configuration words over a three-pin serial link (serial clock, serial data, latch enable) that runs asynchronously to the system clock. Every pin is brought into the system clock domain through a synchroniser. Edges are found on the synchronised copies. Each rising edge of the serial clock shifts one data bit into a 22-bit shift register, with the most significant bit sent first.

A rising edge of latch enable copies the whole shift register into one of four holding registers. The two lowest bits of the word pick the destination. The holding registers feed the reference divider, the feedback divider and two groups of function settings. Decoding inside each word is left to those consumers. The one exception is the prescaler modulus bit of the feedback word, which the block brings out directly.

Each holding register has a one-cycle update strobe, so a consumer can tell when new settings have arrived.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is active, and on leaving it, all four holding registers are zero, all update strobes are low and the prescaler select is low.
- R2: Each rising edge of the serial clock, while latch enable is low, shifts one data bit into the shift register. The first bit sent ends up in bit 21 and the last bit sent ends up in bit 0.
- R3: Word bits [1:0] choose the destination: 0 is the reference word, 1 is the feedback word, 2 is function word A and 3 is function word B. The other three registers keep their values.
- R4: A transfer happens only on a rising edge of latch enable. Holding latch enable high, or lowering it, does not cause a further transfer.
- R5: Serial clock edges that arrive while latch enable is high leave the shift register unchanged. A later latch-enable pulse therefore transfers the same word again.
- R6: Each transfer raises exactly one update strobe for exactly one system clock cycle: the strobe of the destination register. It is raised in the same cycle in which that register shows its new value.
- R7: The prescaler select output equals bit 20 of the feedback word. It changes only when that word is updated.
- R8: When more than 22 bits are shifted in before a latch-enable pulse, only the last 22 bits are transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Latch enable, asynchronous |
| ref_word | output | 22 | Holding register, address 0 (reference divider) |
| fb_word | output | 22 | Holding register, address 1 (feedback divider) |
| fna_word | output | 22 | Holding register, address 2 (function settings A) |
| fnb_word | output | 22 | Holding register, address 3 (function settings B) |
| upd_stb | output | 4 | One-cycle update strobe, bit i for address i |
| prescale_sel | output | 1 | Prescaler modulus select, bit 20 of fb_word |

## Verification
The hardest case to reach is serial clock activity while latch enable is high. It needs a transfer already latched and then clock edges that carry ones on the data pin. The stimulus raises latch enable and toggles the serial clock several times with data high. It then lowers latch enable and pulses it again. The second transfer must reproduce the earlier word exactly. A second case sends a stream longer than 22 bits, to show that the leading bits fall out of the shift register. A behavioural model tracks every synchronised edge and is compared against all outputs on every clock.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int WORD_W   = 22,
  parameter int SYNC_N   = 2,
  parameter int PSEL_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [WORD_W-1:0] ref_word,
  output logic [WORD_W-1:0] fb_word,
  output logic [WORD_W-1:0] fna_word,
  output logic [WORD_W-1:0] fnb_word,
  output logic [3:0]        upd_stb,
  output logic              prescale_sel
);
  localparam int NLAT = 4;

  logic [SYNC_N-1:0] sck_q, dat_q, le_q;
  logic              sck_d, le_d;
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] lat [NLAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      dat_q <= '0;
      le_q  <= '0;
      sck_d <= 1'b0;
      le_d  <= 1'b0;
    end else begin
      sck_q <= {sck_q[SYNC_N-2:0], ser_clk};
      dat_q <= {dat_q[SYNC_N-2:0], ser_dat};
      le_q  <= {le_q[SYNC_N-2:0], ser_le};
      sck_d <= sck_q[SYNC_N-1];
      le_d  <= le_q[SYNC_N-1];
    end
  end

  wire le_hi   = le_q[SYNC_N-1];
  wire sck_rise = sck_q[SYNC_N-1] & ~sck_d;
  wire le_rise  = le_hi & ~le_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sr <= '0;
    else if (sck_rise && !le_hi) sr <= {sr[WORD_W-2:0], dat_q[SYNC_N-1]};
  end

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          lat[i] <= '0;
      else if (le_rise && sr[1:0] == 2'(i)) lat[i] <= sr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       upd_stb <= '0;
    else if (le_rise) upd_stb <= 4'b0001 << sr[1:0];
    else              upd_stb <= '0;
  end

  assign ref_word     = lat[0];
  assign fb_word      = lat[1];
  assign fna_word     = lat[2];
  assign fnb_word     = lat[3];
  assign prescale_sel = lat[1][PSEL_BIT];
endmodule

module cfg_serial_loader_chk #(
  parameter int WORD_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] ref_word,
  input logic [WORD_W-1:0] fb_word,
  input logic [WORD_W-1:0] fna_word,
  input logic [WORD_W-1:0] fnb_word,
  input logic [3:0]        upd_stb,
  input logic              prescale_sel
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ref_word == '0 && fb_word == '0 && fna_word == '0 &&
                fnb_word == '0 && upd_stb == '0 && !prescale_sel));
  // R6
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_stb));
  // R6
  stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb != '0) |=> (upd_stb == '0));
  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[0] |-> $stable(ref_word));
  // R3
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[1] |-> $stable(fb_word));
  // R3
  fna_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[2] |-> $stable(fna_word));
  // R3
  fnb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[3] |-> $stable(fnb_word));
  // R7
  psel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb[1] |-> $stable(prescale_sel));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ref_word(ref_word), .fb_word(fb_word),
  .fna_word(fna_word), .fnb_word(fnb_word), .upd_stb(upd_stb),
  .prescale_sel(prescale_sel)
);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_le = 0;
  logic [21:0] ref_word, fb_word, fna_word, fnb_word;
  logic [3:0]  upd_stb;
  logic        prescale_sel;

  int checks = 0, fails = 0;
  int stb_cnt [4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  cfg_serial_loader i_cfg_serial_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .ref_word(ref_word), .fb_word(fb_word),
    .fna_word(fna_word), .fnb_word(fnb_word), .upd_stb(upd_stb),
    .prescale_sel(prescale_sel)
  );

  // behavioural reference model
  bit [2:0]    hist [$] = '{3'b0, 3'b0, 3'b0, 3'b0};
  logic [21:0] m_sr;
  logic [21:0] m_lat [4];
  logic [3:0]  m_stb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_sr = 0;
      foreach (m_lat[i]) m_lat[i] = 0;
      m_stb = 0;
    end else begin
      bit [2:0] cur, old;
      hist.push_front({ser_le, ser_dat, ser_clk});
      void'(hist.pop_back());
      cur = hist[2];
      old = hist[3];
      m_stb = 0;
      if (cur[2] && !old[2]) begin
        m_lat[m_sr[1:0]] = m_sr;
        m_stb[m_sr[1:0]] = 1'b1;
      end
      if (cur[0] && !old[0] && !cur[2]) m_sr = {m_sr[20:0], cur[1]};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(ref_word == m_lat[0], "R2/R3 ref_word", 32'(ref_word), 32'(m_lat[0]));
    chk(fb_word  == m_lat[1], "R2/R3 fb_word",  32'(fb_word),  32'(m_lat[1]));
    chk(fna_word == m_lat[2], "R2/R3 fna_word", 32'(fna_word), 32'(m_lat[2]));
    chk(fnb_word == m_lat[3], "R2/R3 fnb_word", 32'(fnb_word), 32'(m_lat[3]));
    chk(upd_stb  == m_stb,    "R6 upd_stb",     32'(upd_stb),  32'(m_stb));
    chk(prescale_sel == m_lat[1][20], "R7 prescale_sel", 32'(prescale_sel), 32'(m_lat[1][20]));
    for (int i = 0; i < 4; i++) if (upd_stb[i]) stb_cnt[i]++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = w[b];
      ser_clk = 0;
      wait_clk(3);
      ser_clk = 1;
      wait_clk(3);
    end
    ser_clk = 0;
    wait_clk(3);
  endtask

  task automatic pulse_le();
    ser_le = 1;
    wait_clk(5);
    ser_le = 0;
    wait_clk(5);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [21:0] w;
    int c;
    wait_clk(4);
    // R1
    chk(ref_word == 0 && fb_word == 0 && fna_word == 0 && fnb_word == 0,
        "R1 latches in reset", 32'(ref_word | fb_word | fna_word | fnb_word), 0);
    chk(upd_stb == 0 && !prescale_sel, "R1 strobes in reset", 32'({upd_stb, prescale_sel}), 0);
    rst_n = 1;
    wait_clk(4);
    chk(ref_word == 0 && fnb_word == 0, "R1 after reset", 32'(ref_word | fnb_word), 0);

    // R2 R3: address 0
    w = 22'h2ABCD4;
    send_bits(32'(w), 22);
    pulse_le();
    chk(ref_word == w, "R2 ref_word MSB first", 32'(ref_word), 32'(w));
    chk(fb_word == 0 && fna_word == 0 && fnb_word == 0, "R3 others unchanged",
        32'(fb_word | fna_word | fnb_word), 0);
    chk(stb_cnt[0] == 1, "R6 strobe count addr0", 32'(stb_cnt[0]), 1);

    // R7: address 1 with bit 20 set, then clear
    w = 22'h1F0F05;
    send_bits(32'(w), 22);
    pulse_le();
    chk(fb_word == w, "R3 fb_word", 32'(fb_word), 32'(w));
    chk(prescale_sel == 1'b1, "R7 prescale_sel set", 32'(prescale_sel), 1);
    w = 22'h2F0F05;
    send_bits(32'(w), 22);
    pulse_le();
    chk(prescale_sel == 1'b0, "R7 prescale_sel clear", 32'(prescale_sel), 0);

    // R3: addresses 2 and 3
    send_bits(32'h155556, 22);
    pulse_le();
    chk(fna_word == 22'h155556, "R3 fna_word", 32'(fna_word), 32'h155556);
    send_bits(32'h0AAAAB, 22);
    pulse_le();
    chk(fnb_word == 22'h0AAAAB, "R3 fnb_word", 32'(fnb_word), 32'h0AAAAB);
    chk(ref_word == 22'h2ABCD4, "R3 ref_word kept", 32'(ref_word), 32'h2ABCD4);

    // R4: long latch-enable high gives a single transfer
    c = stb_cnt[3];
    ser_le = 1;
    wait_clk(40);
    ser_le = 0;
    wait_clk(10);
    chk(stb_cnt[3] == c + 1, "R4 one transfer per rise", 32'(stb_cnt[3]), 32'(c + 1));

    // R5: serial clocks while latch enable high do not shift
    ser_le = 1;
    wait_clk(5);
    send_bits(32'hFFFFFFFF, 6);
    ser_le = 0;
    wait_clk(5);
    pulse_le();
    chk(fnb_word == 22'h0AAAAB, "R5 word unchanged by clocks under le", 32'(fnb_word), 32'h0AAAAB);
    chk(stb_cnt[3] == c + 3, "R5 retransfer strobe", 32'(stb_cnt[3]), 32'(c + 3));

    // R8: 28 bits sent, last 22 kept
    send_bits(32'h0FC12344, 28);
    pulse_le();
    chk(ref_word == 22'h012344, "R8 oversize stream", 32'(ref_word), 32'h012344);
    chk(stb_cnt[0] == 2, "R6 strobe count addr0 final", 32'(stb_cnt[0]), 2);

    // R1: reset again
    rst_n = 0;
    wait_clk(3);
    chk(ref_word == 0 && fb_word == 0 && fna_word == 0 && fnb_word == 0,
        "R1 second reset", 32'(ref_word | fb_word | fna_word | fnb_word), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule